// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

The unpacker sits between a framebuffer fetch engine and a colour pipeline. It takes 32-bit framebuffer words over a valid/ready handshake and emits one pixel per cycle over a second valid/ready handshake. In the low depths (1, 2, 4 and 8 bits per pixel) each pixel is a palette index. In the high depths (16, 12 and 32 bits per pixel) each pixel is a direct 24-bit colour, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.

The depth, both big-endian controls, the blue/red swap and the external 16-bit format selector are captured together with each accepted word. Changing them therefore never disturbs a word that is partly emitted. A separate combinational output gives the number of bytes that one display line occupies, computed from the live column count and the live depth code.

The parameter `NATIVE_565` picks the variant. With 0 (the default), depth code 4 uses the external format selector. With 1, depth code 4 is always 5551.

Top module: `fb_pixel_unpack`

## Requirements
- R1: Depth code on `depth_i` (0=1, 1=2, 2=4, 3=8, 4=16 first format, 5=32, 6=16 565, 7=12 bits per pixel) sets the pixels per word: 32, 16, 8, 4, 2, 1 and 2 (12-bit pixels sit in 16-bit slots). With both big-endian controls clear, pixel k is taken from bits starting at k times the slot width, least significant first.
- R2: Codes 0..3 give `pix_direct_o`=0 and a zero-extended index on `pix_index_o`, with `pix_rgb_o`=0. Codes 4..7 give `pix_direct_o`=1 and `pix_index_o`=0.
- R3: With `be_byte_i`=1, pixel k is taken from the most significant end of the word, occupying bits [31-k*w -: w] for slot width w.
- R4: With only `be_pix_i`=1, bytes are taken least significant first, but sub-byte pixels within each byte are taken most significant first. At 8 bits and above this control has no effect.
- R5: When both big-endian controls are set, the byte order of R3 applies.
- R6: 5551 format: bits 4:0, 9:5 and 14:10 are three 5-bit fields. Each field is widened to 8 bits by a left shift of 3 with zero fill. Bit 15 is ignored. With `bgr_i`=0 the low field is red and the top field is blue; with `bgr_i`=1 the two swap.
- R7: 565 format: bits 4:0 and 15:11 are 5-bit fields and bits 10:5 form a 6-bit green field widened by a shift of 2. The low field is red when `bgr_i`=0 and blue when `bgr_i`=1. Code 6 always uses 565. Code 4 uses 565 honouring `bgr_i` when `mux_sel_i` is 0 or 2.
- R8: In code 4 with `NATIVE_565`=0, `mux_sel_i`=1 selects 5551 honouring `bgr_i`, and `mux_sel_i`=3 selects 565 with the low field forced to blue regardless of `bgr_i`.
- R9: 12 bpp: nibbles 3:0, 7:4 and 11:8 of each 16-bit slot are widened by a shift of 4. The low nibble is red unless `bgr_i` swaps it with blue. Bits 15:12 are ignored.
- R10: 32 bpp: byte 0 is red unless `bgr_i` swaps it with byte 2. Byte 1 is green and byte 3 is ignored.
- R11: `line_bytes_o` equals `cols_i` divided by 8, 4 or 2 for codes 0, 1 and 2. It equals `cols_i` for code 3, `cols_i` times 2 for codes 4, 6 and 7, and `cols_i` times 4 for code 5.
- R12: A new word is accepted only when no pixel is pending, or in the same cycle that the last pixel of the current word is taken. While `pix_valid_o`=1 and `pix_ready_i`=0, the pixel outputs hold and no word is accepted.
- R13: After reset `pix_valid_o`=0 and `word_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cols_i | input | COL_W | Pixels per line |
| depth_i | input | 3 | Depth code |
| be_byte_i | input | 1 | Big-endian byte order |
| be_pix_i | input | 1 | Big-endian pixel order within a byte |
| bgr_i | input | 1 | Swap red and blue fields |
| mux_sel_i | input | 2 | External 16-bit format selector |
| word_valid_i | input | 1 | Input word valid |
| word_data_i | input | 32 | Framebuffer word |
| word_ready_o | output | 1 | Input word accepted this cycle when valid |
| pix_valid_o | output | 1 | Pixel valid |
| pix_ready_i | input | 1 | Pixel consumer ready |
| pix_direct_o | output | 1 | Pixel is direct colour |
| pix_index_o | output | 8 | Palette index |
| pix_rgb_o | output | 24 | Direct colour, red high |
| line_bytes_o | output | COL_W+2 | Bytes per display line |

## Verification
The palette depths are driven with one irregular word per depth code. This shows whether the slot width and the number of pixels per word are right. The 4-bit and 2-bit depths are then repeated with each big-endian control and with both. These give three distinct index orders, which separate whole-word reversal, per-byte reversal and the priority between them. The direct depths use words whose fields hold all-ones in one place and zeros elsewhere, with the ignored top bit set. A swapped field, a wrong widening shift or a wrong selector decode therefore each give a different colour. A stall test holds the consumer off while a second word is offered, and shows whether the held pixel and the word boundary are respected.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    DEPTH_1   = 3'd0,
    DEPTH_2   = 3'd1,
    DEPTH_4   = 3'd2,
    DEPTH_8   = 3'd3,
    DEPTH_16A = 3'd4,
    DEPTH_32  = 3'd5,
    DEPTH_16B = 3'd6,
    DEPTH_12  = 3'd7
  } depth_e;

  typedef struct packed {
    depth_e     depth;
    logic       be_byte;
    logic       be_pix;
    logic       bgr;
    logic [1:0] mux;
  } cfg_t;

  // log2 of the slot width in bits
  function automatic logic [2:0] slot_lg(depth_e d);
    case (d)
      DEPTH_1:   return 3'd0;
      DEPTH_2:   return 3'd1;
      DEPTH_4:   return 3'd2;
      DEPTH_8:   return 3'd3;
      DEPTH_32:  return 3'd5;
      default:   return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/fbu_slot_sel.sv
module fbu_slot_sel
  import fbu_pkg::*;
(
  input  depth_e           depth_i,
  input  logic             be_byte_i,
  input  logic             be_pix_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             last_o,
  output logic [IDX_W-1:0] bit_off_o
);
  logic [2:0]       lg;
  logic [IDX_W:0]   ppw;
  logic [IDX_W-1:0] ppw_m1;
  logic [IDX_W-1:0] ppb_m1;
  logic [IDX_W-1:0] slot;

  always_comb begin
    lg     = slot_lg(depth_i);
    ppw    = (IDX_W+1)'(WORD_W) >> lg;
    ppw_m1 = IDX_W'(ppw - 1'b1);
    ppb_m1 = (lg < 3'd3) ? IDX_W'((4'd8 >> lg) - 4'd1) : '0;
    if (be_byte_i)     slot = idx_i ^ ppw_m1;
    else if (be_pix_i) slot = idx_i ^ ppb_m1;
    else               slot = idx_i;
    bit_off_o = slot << lg;
    last_o    = (idx_i == ppw_m1);
  end
endmodule

// File: rtl/fbu_color_fmt.sv
module fbu_color_fmt
  import fbu_pkg::*;
#(
  parameter bit NATIVE_565 = 1'b0
) (
  input  depth_e      depth_i,
  input  logic        bgr_i,
  input  logic [1:0]  mux_i,
  input  logic [23:0] raw_i,
  output logic        direct_o,
  output logic [7:0]  index_o,
  output logic [23:0] rgb_o
);
  typedef enum logic [2:0] {F_IDX, F_5551, F_565, F_444, F_888} fmt_e;

  fmt_e       fmt;
  logic       swap;
  logic [7:0] c0, c1, c2;
  logic [7:0] idx_mask;

  always_comb begin
    fmt      = F_IDX;
    swap     = bgr_i;
    idx_mask = 8'h00;
    case (depth_i)
      DEPTH_1:   idx_mask = 8'h01;
      DEPTH_2:   idx_mask = 8'h03;
      DEPTH_4:   idx_mask = 8'h0f;
      DEPTH_8:   idx_mask = 8'hff;
      DEPTH_16A: begin
        if (NATIVE_565 || mux_i == 2'd1) fmt = F_5551;
        else begin
          fmt = F_565;
          if (mux_i == 2'd3) swap = 1'b1;
        end
      end
      DEPTH_16B: fmt = F_565;
      DEPTH_12:  fmt = F_444;
      DEPTH_32:  fmt = F_888;
      default:   fmt = F_IDX;
    endcase
  end

  always_comb begin
    c0 = '0; c1 = '0; c2 = '0;
    case (fmt)
      F_5551: begin
        c0 = {raw_i[4:0], 3'b0};
        c1 = {raw_i[9:5], 3'b0};
        c2 = {raw_i[14:10], 3'b0};
      end
      F_565: begin
        c0 = {raw_i[4:0], 3'b0};
        c1 = {raw_i[10:5], 2'b0};
        c2 = {raw_i[15:11], 3'b0};
      end
      F_444: begin
        c0 = {raw_i[3:0], 4'b0};
        c1 = {raw_i[7:4], 4'b0};
        c2 = {raw_i[11:8], 4'b0};
      end
      F_888: begin
        c0 = raw_i[7:0];
        c1 = raw_i[15:8];
        c2 = raw_i[23:16];
      end
      default: ;
    endcase
  end

  always_comb begin
    direct_o = (fmt != F_IDX);
    index_o  = direct_o ? 8'h00 : (raw_i[7:0] & idx_mask);
    if (!direct_o) rgb_o = '0;
    else if (swap) rgb_o = {c2, c1, c0};
    else           rgb_o = {c0, c1, c2};
  end
endmodule

// File: rtl/fbu_line_bytes.sv
module fbu_line_bytes
  import fbu_pkg::*;
#(
  parameter int unsigned COL_W = 12
) (
  input  logic [COL_W-1:0] cols_i,
  input  depth_e           depth_i,
  output logic [COL_W+1:0] line_bytes_o
);
  logic [COL_W+1:0] c;

  always_comb begin
    c = {2'b00, cols_i};
    case (depth_i)
      DEPTH_1:  line_bytes_o = c >> 3;
      DEPTH_2:  line_bytes_o = c >> 2;
      DEPTH_4:  line_bytes_o = c >> 1;
      DEPTH_8:  line_bytes_o = c;
      DEPTH_32: line_bytes_o = c << 2;
      default:  line_bytes_o = c << 1;
    endcase
  end
endmodule

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack
  import fbu_pkg::*;
#(
  parameter int unsigned COL_W      = 12,
  parameter bit          NATIVE_565 = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COL_W-1:0]  cols_i,
  input  logic [2:0]        depth_i,
  input  logic              be_byte_i,
  input  logic              be_pix_i,
  input  logic              bgr_i,
  input  logic [1:0]        mux_sel_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic              pix_direct_o,
  output logic [7:0]        pix_index_o,
  output logic [23:0]       pix_rgb_o,
  output logic [COL_W+1:0]  line_bytes_o
);
  cfg_t              cfg_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full_q;
  logic              last;
  logic [IDX_W-1:0]  bit_off;
  logic [23:0]       raw;
  logic              pop;
  logic              accept;

  assign pop          = full_q & pix_ready_i;
  assign word_ready_o = ~full_q | (pop & last);
  assign accept       = word_valid_i & word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      word_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      cfg_q  <= '{depth: depth_e'(depth_i), be_byte: be_byte_i, be_pix: be_pix_i,
                  bgr: bgr_i, mux: mux_sel_i};
      word_q <= word_data_i;
      idx_q  <= '0;
      full_q <= 1'b1;
    end else if (pop) begin
      if (last) full_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  fbu_slot_sel u_slot (
    .depth_i   (cfg_q.depth),
    .be_byte_i (cfg_q.be_byte),
    .be_pix_i  (cfg_q.be_pix),
    .idx_i     (idx_q),
    .last_o    (last),
    .bit_off_o (bit_off)
  );

  assign raw = 24'(word_q >> bit_off);

  fbu_color_fmt #(.NATIVE_565(NATIVE_565)) u_fmt (
    .depth_i  (cfg_q.depth),
    .bgr_i    (cfg_q.bgr),
    .mux_i    (cfg_q.mux),
    .raw_i    (raw),
    .direct_o (pix_direct_o),
    .index_o  (pix_index_o),
    .rgb_o    (pix_rgb_o)
  );

  assign pix_valid_o = full_q;

  fbu_line_bytes #(.COL_W(COL_W)) u_lb (
    .cols_i       (cols_i),
    .depth_i      (depth_e'(depth_i)),
    .line_bytes_o (line_bytes_o)
  );
endmodule

// File: rtl/fb_pixel_unpack_chk.sv
module fb_pixel_unpack_chk #(
  parameter int unsigned COL_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [COL_W-1:0] cols_i,
  input logic [2:0]       depth_i,
  input logic             word_ready_o,
  input logic             pix_valid_o,
  input logic             pix_ready_i,
  input logic             pix_direct_o,
  input logic [7:0]       pix_index_o,
  input logic [23:0]      pix_rgb_o,
  input logic [COL_W+1:0] line_bytes_o
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(pix_index_o) && $stable(pix_rgb_o) && $stable(pix_direct_o)); // R12

  AST_NO_ACCEPT_MIDWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |-> !word_ready_o); // R12

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> word_ready_o); // R13

  AST_INDEX_HAS_NO_RGB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_direct_o |-> pix_rgb_o == 24'h0); // R2

  AST_RGB_HAS_NO_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_direct_o |-> pix_index_o == 8'h0); // R2

  AST_LINE_BYTES_BYTE_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i == 3'd3 |-> line_bytes_o == {2'b00, cols_i}); // R11

  AST_LINE_BYTES_WORD_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i == 3'd5 |-> line_bytes_o == ({2'b00, cols_i} << 2)); // R11
endmodule

bind fb_pixel_unpack fb_pixel_unpack_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/fb_pixel_unpack_tb_top.sv
module fb_pixel_unpack_tb_top;
  localparam int COL_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [COL_W-1:0] cols = '0;
  logic [2:0]       depth = '0;
  logic             be_byte = 1'b0, be_pix = 1'b0, bgr = 1'b0;
  logic [1:0]       mux_sel = '0;
  logic             word_valid = 1'b0;
  logic [31:0]      word_data = '0;
  logic             word_ready, pix_valid, pix_direct;
  logic             pix_ready = 1'b0;
  logic [7:0]       pix_index;
  logic [23:0]      pix_rgb;
  logic [COL_W+1:0] line_bytes;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  fb_pixel_unpack #(.COL_W(COL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cols_i(cols), .depth_i(depth),
    .be_byte_i(be_byte), .be_pix_i(be_pix), .bgr_i(bgr), .mux_sel_i(mux_sel),
    .word_valid_i(word_valid), .word_data_i(word_data), .word_ready_o(word_ready),
    .pix_valid_o(pix_valid), .pix_ready_i(pix_ready), .pix_direct_o(pix_direct),
    .pix_index_o(pix_index), .pix_rgb_o(pix_rgb), .line_bytes_o(line_bytes)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int d, bit bb, bit bp, bit sw, int mx);
    @(negedge clk);
    depth = 3'(d); be_byte = bb; be_pix = bp; bgr = sw; mux_sel = 2'(mx);
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    word_valid = 1'b1; word_data = w;
    forever begin
      if (word_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    #1 word_valid = 1'b0;
  endtask

  task automatic pull_idx(string tag, logic [7:0] exp);
    @(negedge clk);
    chk({tag, " valid"}, 32'(pix_valid), 32'd1);
    chk({tag, " R2 direct"}, 32'(pix_direct), 32'd0);
    chk(tag, 32'(pix_index), 32'(exp));
    pix_ready = 1'b1;
    @(posedge clk);
    #1 pix_ready = 1'b0;
  endtask

  task automatic pull_rgb(string tag, logic [23:0] exp);
    @(negedge clk);
    chk({tag, " valid"}, 32'(pix_valid), 32'd1);
    chk({tag, " R2 direct"}, 32'(pix_direct), 32'd1);
    chk(tag, 32'(pix_rgb), 32'(exp));
    pix_ready = 1'b1;
    @(posedge clk);
    #1 pix_ready = 1'b0;
  endtask

  // mode 0: lsb first, 1: word big-endian, 2: big-endian within byte
  function automatic logic [7:0] exp_idx(logic [31:0] w, int b, int mode, int k);
    int pos;
    int ppb;
    case (mode)
      1: pos = 32 - (k + 1) * b;
      2: begin ppb = 8 / b; pos = (k / ppb) * 8 + 8 - ((k % ppb) + 1) * b; end
      default: pos = k * b;
    endcase
    return 8'((w >> pos) & ((32'd1 << b) - 1));
  endfunction

  task automatic run_idx(string tag, int d, int mode_bb, int mode_bp, logic [31:0] w);
    int b;
    int mode;
    b = 1 << d;
    mode = mode_bb ? 1 : (mode_bp && b < 8) ? 2 : 0;
    set_cfg(d, mode_bb != 0, mode_bp != 0, 1'b0, 0);
    send(w);
    for (int k = 0; k < 32 / b; k++)
      pull_idx($sformatf("%s d%0d k%0d", tag, d, k), exp_idx(w, b, mode, k));
  endtask

  task automatic t_reset;
    chk("R13 valid after reset", 32'(pix_valid), 32'd0);
    chk("R13 ready after reset", 32'(word_ready), 32'd1);
  endtask

  task automatic t_palette_le;
    for (int d = 0; d < 4; d++) run_idx("R1 lsb-first", d, 0, 0, 32'hA5C3_1E69 ^ (32'(d) * 32'h0101_0101));
  endtask

  task automatic t_be_byte;
    run_idx("R3 word-be", 2, 1, 0, 32'h7654_3210);
    run_idx("R3 word-be", 0, 1, 0, 32'h8001_F00D);
  endtask

  task automatic t_be_pix;
    run_idx("R4 byte-be", 2, 0, 1, 32'h7654_3210);
    run_idx("R4 byte-be", 1, 0, 1, 32'h1B2D_E4C6);
    run_idx("R4 no effect 8bpp", 3, 0, 1, 32'h4433_2211);
  endtask

  task automatic t_priority;
    run_idx("R5 both set", 2, 1, 1, 32'h7654_3210);
  endtask

  task automatic t_5551;
    set_cfg(4, 0, 0, 0, 1); send(32'h7C00_801F);
    pull_rgb("R6 5551 bit15 ignored", 24'hF80000);
    pull_rgb("R6 5551 top field", 24'h0000F8);
    set_cfg(4, 1, 0, 0, 1); send(32'h7C00_801F);
    pull_rgb("R3 16bpp upper half first", 24'h0000F8);
    pull_rgb("R3 16bpp lower half second", 24'hF80000);
    set_cfg(4, 0, 0, 1, 1); send(32'h7C00_801F);
    pull_rgb("R8 mux1 5551 bgr", 24'h0000F8);
    pull_rgb("R8 mux1 5551 bgr top", 24'hF80000);
  endtask

  task automatic t_565;
    set_cfg(4, 0, 0, 0, 0); send(32'h07E0_F800);
    pull_rgb("R7 mux0 high field blue", 24'h0000F8);
    pull_rgb("R7 mux0 green6", 24'h00FC00);
    set_cfg(4, 0, 0, 1, 0); send(32'h07E0_F800);
    pull_rgb("R7 mux0 bgr high field red", 24'hF80000);
    pull_rgb("R7 mux0 bgr green6", 24'h00FC00);
    set_cfg(4, 0, 0, 0, 2); send(32'h07E0_F800);
    pull_rgb("R7 mux2", 24'h0000F8);
    pull_rgb("R7 mux2 green", 24'h00FC00);
    set_cfg(4, 0, 0, 0, 3); send(32'h07E0_F800);
    pull_rgb("R8 mux3 forced bgr", 24'hF80000);
    pull_rgb("R8 mux3 green", 24'h00FC00);
    set_cfg(6, 0, 0, 0, 1); send(32'h07E0_F800);
    pull_rgb("R7 code6 ignores mux", 24'h0000F8);
    pull_rgb("R7 code6 green", 24'h00FC00);
  endtask

  task automatic t_12;
    set_cfg(7, 0, 0, 0, 0); send(32'hF000_0ABC);
    pull_rgb("R9 444", 24'hC0B0A0);
    pull_rgb("R9 top nibble ignored", 24'h000000);
    set_cfg(7, 0, 0, 1, 0); send(32'h0000_0ABC);
    pull_rgb("R9 444 bgr", 24'hA0B0C0);
    pull_rgb("R9 444 bgr zero", 24'h000000);
  endtask

  task automatic t_32;
    set_cfg(5, 0, 0, 0, 0); send(32'hFF11_2233);
    pull_rgb("R10 888", 24'h332211);
    set_cfg(5, 0, 0, 1, 0); send(32'hFF11_2233);
    pull_rgb("R10 888 bgr", 24'h112233);
  endtask

  task automatic t_line_bytes;
    int exp_lb [8] = '{80, 160, 320, 640, 1280, 2560, 1280, 1280};
    @(negedge clk);
    cols = 12'd640;
    for (int d = 0; d < 8; d++) begin
      depth = 3'(d);
      #1 chk($sformatf("R11 line bytes d%0d", d), 32'(line_bytes), 32'(exp_lb[d]));
    end
  endtask

  task automatic t_stall;
    set_cfg(3, 0, 0, 0, 0);
    send(32'h4433_2211);
    pull_idx("R12 first", 8'h11);
    @(negedge clk);
    word_valid = 1'b1; word_data = 32'h8877_6655;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 held index", 32'(pix_index), 32'h22);
      chk("R12 no accept mid-word", 32'(word_ready), 32'd0);
    end
    pull_idx("R12 after stall", 8'h22);
    pull_idx("R12 third", 8'h33);
    @(negedge clk);
    chk("R12 last pixel", 32'(pix_index), 32'h44);
    pix_ready = 1'b1;
    #1 chk("R12 ready on last pop", 32'(word_ready), 32'd1);
    @(posedge clk);
    #1 begin pix_ready = 1'b0; word_valid = 1'b0; end
    pull_idx("R12 next word b0", 8'h55);
    pull_idx("R12 next word b1", 8'h66);
    pull_idx("R12 next word b2", 8'h77);
    pull_idx("R12 next word b3", 8'h88);
    @(negedge clk);
    chk("R12 drained", 32'(pix_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_palette_le();
    t_be_byte();
    t_be_pix();
    t_priority();
    t_5551();
    t_565();
    t_12();
    t_32();
    t_line_bytes();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule